// File: doc/BRIEF.md
# Watchdog timer controller

This block is a countdown watchdog that sits behind a 32-bit register port addressed by byte, where only word-aligned accesses take effect. Software loads a reload value, arms the timer through the control register, and must keep writing a fixed 16-bit key to the restart register before the count runs out. The counter steps down on a selected tick. The tick is normally the 1 MHz enable pulse, and the control value is forced so that this pulse is always chosen while the block counts.

When the count runs out, the block raises a one-cycle system reset request and stops counting. If the corresponding control bits are set, it also pulses an interrupt for one cycle and drives a reset output to its active level for a programmed number of ticks. An external hold input, asserted while the memory controller is being reset, turns expiry into a silent disarm: the control register is cleared and no request is raised.

The reset-width register sets the pulse length. Its two configuration bits, output polarity and drive type, change only when the written top byte matches one of four key values.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, the counter (offset 0x00) and the reload value (0x04) read 0x014FB180, the control register (0x0C) reads 0x00000010, the reset-width register (0x18) reads 0x000000FF, and the restart offset (0x08) reads 0. The request and interrupt outputs are low, and the reset output is at its idle level, which is high because the output is active-low at reset.
- R2: The reload register is read/write. Writes to the counter offset 0x00 are ignored.
- R3: A write to 0x08 whose low 16 bits equal 0x4755 copies the reload value into the counter. The countdown restarts only if enable (control bit 0) is set. A write with any other low half has no effect.
- R4: A control write is stored with bits 11:8 cleared and bit 4 forced to 1. Bit 0 is enable, bit 1 is reset on expiry, and bit 2 is interrupt on expiry.
- R5: A control write that changes enable from 0 to 1 loads the counter from the reload value and starts counting. A write that changes it from 1 to 0 freezes the counter. A write that leaves enable at 1 does not reload.
- R6: While armed, the counter drops by one on each selected tick. Control bit 4 set selects `tick_1mhz`, and clear selects every clock. If a valid restart arrives in the same cycle as a tick, the counter is reloaded and the tick is ignored.
- R7: The tick that takes the counter from 1 to 0, or any tick while the counter is at 0, is an expiry. Without the hold input, `sys_rst_req` is high for exactly the next cycle, and the counter stays at 0 with no further expiry. The control register is left unchanged.
- R8: An expiry while `mem_hold` is high clears the control register to 0 and stops the timer. It produces no request, no interrupt and no reset pulse.
- R9: An expiry without hold, with control bit 2 set, pulses `irq` together with `sys_rst_req` for one cycle.
- R10: An expiry without hold, with control bit 1 set, drives the reset output active for N selected ticks, where N is bits 19:0 of the reset-width register. When N = 0, no pulse is produced.
- R11: Reset-width writes with top byte 0xA5 set bit 31, and 0x5A clears it. Top byte 0xA8 sets bit 30, and 0x8A clears it. Any other top byte leaves both bits unchanged. Bit 31 set makes the reset output active-high, and clear makes it active-low. Bit 30 appears on `rst_push_pull`.
- R12: Every reset-width write replaces bits 19:0 with the written data and keeps bits 29:20.
- R13: Offset 0x1C stores and returns its data. Offsets 0x10, 0x14, 0x20, 0x24, 0x28, 0x2C and all higher offsets read 0 and ignore writes. Accesses whose two low address bits are non-zero read 0 and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational from address |
| tick_1mhz | input | 1 | 1 MHz enable pulse |
| mem_hold | input | 1 | Memory-controller reset hold; disarms on expiry |
| sys_rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle expiry interrupt |
| rst_out | output | 1 | Reset pulse output at programmed polarity |
| rst_push_pull | output | 1 | Drive-type configuration bit |

## Verification
The countdown is driven with ticks alone, ticks mixed with control writes that keep enable at 1 or clear it, and a restart written in the same cycle as a tick. Together these separate a true decrement from a spurious reload and show that the restart takes priority. Expiry is tried with the hold input high and low, with the interrupt and reset bits set, and with a zero pulse width, which distinguishes disarming from requesting and shows that pulse length is counted in ticks. Key bytes are written in sequence with a non-key byte between them, which confirms that only the exact keys move the polarity and drive bits while the width field is always replaced.

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] CNT_INIT   = 32'h014F_B180,
  parameter logic [15:0] RESTART_KEY = 16'h4755,
  parameter int          PW_BITS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  input  logic              tick_1mhz,
  input  logic              mem_hold,
  output logic              sys_rst_req,
  output logic              irq,
  output logic              rst_out,
  output logic              rst_push_pull
);

  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_CNT = WW'(0);
  localparam logic [WW-1:0] W_RLD = WW'(1);
  localparam logic [WW-1:0] W_RST = WW'(2);
  localparam logic [WW-1:0] W_CTL = WW'(3);
  localparam logic [WW-1:0] W_PW  = WW'(6);
  localparam logic [WW-1:0] W_MSK = WW'(7);
  localparam logic [31:0] CTL_CLR = 32'h0000_0F00;
  localparam logic [31:0] CTL_SET = 32'h0000_0010;

  logic [31:0] cnt_q, reload_q, ctrl_q, pw_q, mask_q;
  logic        armed_q;
  logic [PW_BITS-1:0] pcnt_q;

  logic [WW-1:0] word;
  logic aligned, wr, rd;
  assign word    = req_addr[ADDR_W-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign wr      = req_valid & req_write & aligned;
  assign rd      = req_valid & ~req_write & aligned;

  logic [31:0] ctl_new;
  logic restart, en_rise, en_fall, tick_sel, expire, fire;
  assign ctl_new  = (req_wdata & ~CTL_CLR) | CTL_SET;
  assign restart  = wr && word == W_RST && req_wdata[15:0] == RESTART_KEY;
  assign en_rise  = wr && word == W_CTL && ctl_new[0] && !ctrl_q[0];
  assign en_fall  = wr && word == W_CTL && !ctl_new[0] && ctrl_q[0];
  assign tick_sel = ctrl_q[4] ? tick_1mhz : 1'b1;
  assign expire   = armed_q && tick_sel && cnt_q <= 32'd1 && !restart && !en_rise && !en_fall;
  assign fire     = expire && !mem_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_INIT;
      armed_q <= 1'b0;
    end else if (restart || en_rise) begin
      cnt_q   <= reload_q;
      armed_q <= en_rise | ctrl_q[0];
    end else if (en_fall) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick_sel) begin
      if (cnt_q <= 32'd1) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 32'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_INIT;
      ctrl_q   <= CTL_SET;
      mask_q   <= '0;
      pw_q     <= 32'h0000_00FF;
    end else begin
      if (wr && word == W_RLD) reload_q <= req_wdata;
      if (wr && word == W_MSK) mask_q <= req_wdata;
      if (wr && word == W_CTL) ctrl_q <= ctl_new;
      else if (expire && mem_hold) ctrl_q <= '0;
      if (wr && word == W_PW) begin
        pw_q[PW_BITS-1:0] <= req_wdata[PW_BITS-1:0];
        case (req_wdata[31:24])
          8'hA5:   pw_q[31] <= 1'b1;
          8'h5A:   pw_q[31] <= 1'b0;
          8'hA8:   pw_q[30] <= 1'b1;
          8'h8A:   pw_q[30] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
      irq         <= 1'b0;
      pcnt_q      <= '0;
    end else begin
      sys_rst_req <= fire;
      irq         <= fire & ctrl_q[2];
      if (fire && ctrl_q[1]) pcnt_q <= pw_q[PW_BITS-1:0];
      else if (pcnt_q != '0 && tick_sel) pcnt_q <= pcnt_q - 1'b1;
    end
  end

  logic active;
  assign active        = (pcnt_q != '0);
  assign rst_out       = pw_q[31] ? active : ~active;
  assign rst_push_pull = pw_q[30];

  always_comb begin
    rsp_rdata = '0;
    if (rd) begin
      case (word)
        W_CNT:   rsp_rdata = cnt_q;
        W_RLD:   rsp_rdata = reload_q;
        W_CTL:   rsp_rdata = ctrl_q;
        W_PW:    rsp_rdata = pw_q;
        W_MSK:   rsp_rdata = mask_q;
        default: rsp_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk #(
  parameter int          ADDR_W      = 8,
  parameter logic [15:0] RESTART_KEY = 16'h4755
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        wkey,
  input logic [15:0]       wlow,
  input logic              tick_1mhz,
  input logic              mem_hold,
  input logic              sys_rst_req,
  input logic              irq,
  input logic              sel_1m,
  input logic              pol,
  input logic              armed_q,
  input logic [31:0]       cnt_q,
  input logic [31:0]       reload_q
);

  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PW  = ADDR_W'(24);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R7

  AST_REQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (!armed_q && cnt_q == 32'd0)); // R7

  AST_HELD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !$past(mem_hold)); // R8

  AST_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sys_rst_req); // R9

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_RST && wlow == RESTART_KEY)
      |=> cnt_q == $past(reload_q)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !(req_valid && req_write) && sel_1m && tick_1mhz && cnt_q > 32'd1)
      |=> cnt_q == $past(cnt_q) - 32'd1); // R6

  AST_POL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_PW && wkey == 8'hA5) |=> pol); // R11

endmodule

bind wdog_ctrl wdog_ctrl_chk #(.ADDR_W(ADDR_W), .RESTART_KEY(RESTART_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wkey(req_wdata[31:24]), .wlow(req_wdata[15:0]),
  .tick_1mhz(tick_1mhz), .mem_hold(mem_hold), .sys_rst_req(sys_rst_req),
  .irq(irq), .sel_1m(ctrl_q[4]), .pol(pw_q[31]), .armed_q(armed_q),
  .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic tick_1mhz = 1'b0, mem_hold = 1'b0;
  logic sys_rst_req, irq, rst_out, rst_push_pull;
  int checks = 0, failures = 0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .tick_1mhz(tick_1mhz), .mem_hold(mem_hold), .sys_rst_req(sys_rst_req),
    .irq(irq), .rst_out(rst_out), .rst_push_pull(rst_push_pull));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; tick_1mhz = t;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick_1mhz = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1mhz = 1'b1;
    @(negedge clk); tick_1mhz = 1'b0;
  endtask

  task automatic arm(input logic [31:0] rl, input logic [31:0] c);
    wr(8'h0C, 32'h0); wr(8'h04, rl); wr(8'h0C, c);
  endtask

  task automatic t_reset();
    rd(8'h00, r); chk("R1 counter", r, 32'h014F_B180);
    rd(8'h04, r); chk("R1 reload", r, 32'h014F_B180);
    rd(8'h0C, r); chk("R1 ctrl", r, 32'h10);
    rd(8'h18, r); chk("R1 width", r, 32'hFF);
    rd(8'h08, r); chk("R1 restart reads 0", r, 0);
    chk("R1 outputs", {29'd0, sys_rst_req, irq, rst_out}, 32'b001);
  endtask

  task automatic t_regs();
    wr(8'h04, 32'd5); rd(8'h04, r); chk("R2 reload rw", r, 5);
    wr(8'h00, 32'h1234); rd(8'h00, r); chk("R2 status write ignored", r, 32'h014F_B180);
    wr(8'h1C, 32'hDEAD_BEEF); rd(8'h1C, r); chk("R13 mask stored", r, 32'hDEAD_BEEF);
    wr(8'h10, 32'h55); rd(8'h10, r); chk("R13 unimpl 0x10", r, 0);
    wr(8'h2C, 32'h55); rd(8'h2C, r); chk("R13 unimpl 0x2C", r, 0);
    rd(8'h40, r); chk("R13 out of range", r, 0);
    wr(8'h05, 32'd7); rd(8'h04, r); chk("R13 misaligned write ignored", r, 5);
    rd(8'h05, r); chk("R13 misaligned read", r, 0);
  endtask

  task automatic t_ctrl();
    wr(8'h0C, 32'h0000_0F26); rd(8'h0C, r); chk("R4 sanitize", r, 32'h36);
  endtask

  task automatic t_restart();
    wr(8'h0C, 32'h0); wr(8'h04, 32'd5);
    wr(8'h08, 32'hABCD_4755); rd(8'h00, r); chk("R3 restart loads", r, 5);
    tick(); rd(8'h00, r); chk("R3 disabled no count", r, 5);
    wr(8'h04, 32'd9); wr(8'h08, 32'h0000_4756); rd(8'h00, r); chk("R3 bad key ignored", r, 5);
  endtask

  task automatic t_count();
    arm(32'd3, 32'h1); rd(8'h00, r); chk("R5 enable reloads", r, 3);
    tick(); rd(8'h00, r); chk("R6 decrement", r, 2);
    wr(8'h0C, 32'h3); rd(8'h00, r); chk("R5 no reload when staying on", r, 2);
    tick(); rd(8'h00, r); chk("R6 decrement again", r, 1);
    wr(8'h08, 32'h4755, 1'b1); rd(8'h00, r); chk("R6 restart beats tick", r, 3);
    wr(8'h0C, 32'h0); tick(); rd(8'h00, r); chk("R5 disable freezes", r, 3);
  endtask

  task automatic t_expire();
    wr(8'h18, 32'hA500_0003); rd(8'h18, r); chk("R11 A5 sets pol", r, 32'h8000_0003);
    chk("R11 idle active-high", {31'd0, rst_out}, 0);
    arm(32'd2, 32'h7);
    tick();
    tick();
    chk("R7 req pulse", {31'd0, sys_rst_req}, 1);
    chk("R9 irq pulse", {31'd0, irq}, 1);
    chk("R10 pulse active", {31'd0, rst_out}, 1);
    @(negedge clk);
    chk("R7 req one cycle", {30'd0, sys_rst_req, irq}, 0);
    rd(8'h00, r); chk("R7 counter zero", r, 0);
    tick(); tick();
    chk("R10 still active after 2 ticks", {31'd0, rst_out}, 1);
    tick();
    chk("R10 released after 3 ticks", {31'd0, rst_out}, 0);
    tick();
    chk("R7 no further expiry", {31'd0, sys_rst_req}, 0);
    rd(8'h0C, r); chk("R7 ctrl kept", r, 32'h17);
  endtask

  task automatic t_keys();
    wr(8'h18, 32'hA800_0010); rd(8'h18, r); chk("R11 A8 sets drive", r, 32'hC000_0010);
    chk("R11 push-pull pin", {31'd0, rst_push_pull}, 1);
    wr(8'h18, 32'h5A00_0020); rd(8'h18, r); chk("R11 5A clears pol", r, 32'h4000_0020);
    chk("R11 idle active-low", {31'd0, rst_out}, 1);
    wr(8'h18, 32'h1200_0030); rd(8'h18, r); chk("R12 other key keeps bits", r, 32'h4000_0030);
    wr(8'h18, 32'h8AFF_FFFF); rd(8'h18, r); chk("R12 low 20 replaced", r, 32'h000F_FFFF);
  endtask

  task automatic t_hold();
    wr(8'h18, 32'h4);
    arm(32'd1, 32'h7);
    mem_hold = 1'b1;
    tick();
    chk("R8 no req no irq", {30'd0, sys_rst_req, irq}, 0);
    chk("R8 no pulse", {31'd0, rst_out}, 1);
    mem_hold = 1'b0;
    rd(8'h0C, r); chk("R8 ctrl cleared", r, 0);
    rd(8'h00, r); chk("R8 counter stopped", r, 0);
  endtask

  task automatic t_zero_width();
    wr(8'h18, 32'h0);
    arm(32'd1, 32'h3);
    tick();
    chk("R10 req with zero width", {31'd0, sys_rst_req}, 1);
    chk("R10 zero width no pulse", {31'd0, rst_out}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ctrl();
    t_restart();
    t_count();
    t_expire();
    t_keys();
    t_hold();
    t_zero_width();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule